// File: doc/BRIEF.md
# Three-Level Pulse-Width Symbol Demodulator

This block takes one serial line that carries a fixed-rate pulse-width waveform and turns it back into a 2-bit symbol stream. The line is sampled by a fast local clock that runs at a fixed integer multiple of the carrier rate and is frequency-locked to the sender. In the default setup a 25 MHz carrier is sampled at 100 MHz, so every carrier period is four samples long. The sender encodes a symbol as the number of high samples at the start of each period: one, two or three.

The raw line first passes through a reset-cleared synchroniser chain. A rising edge marks the start of a period. The block counts the high samples and the total samples between two consecutive rising edges. A well-formed period produces a registered symbol and a one-cycle strobe. A malformed period produces a one-cycle error pulse, and the last good symbol stays on the output. After reset, or after the line has gone quiet, the first rising edge only sets up alignment. Decoding starts with the period that this edge opens.

Top module: `pwm_level_demod`

## Requirements
- R1: In a well-formed 4-sample period, a count of 1, 2 or 3 high samples gives `sym_o` = 2'b00, 2'b01 or 2'b10 respectively. The new code appears in the same cycle as its `valid_o` pulse.
- R2: A well-formed period yields exactly one `valid_o` pulse, one cycle wide. It occurs on the second clock edge after the edge that first samples the high level of the next period's rising edge. Pulses are therefore never closer than 4 cycles apart.
- R3: A period starts at a rising edge only. The first rising edge after reset, or after a timeout, produces neither `valid_o` nor `err_o`.
- R4: A rising edge that arrives fewer than 4 samples after the previous one raises `err_o` for one cycle with no `valid_o`. That edge becomes the new period start, so the following period is decoded normally.
- R5: If no rising edge arrives exactly 4 samples after the previous one, `err_o` is raised for one cycle. This covers a line held high (four high samples) and a line held low (zero high samples). The pulse comes at the latency of R2. Decoding then stops until a fresh rising edge re-aligns.
- R6: `sym_o` changes only in a cycle where `valid_o` is high. It keeps the last good code across error periods and between strobes.
- R7: Reset is synchronous and active high. While it is held and after it is released, `sym_o` = 2'b00 and `valid_o` = `err_o` = 0 until the first decoded period.
- R8: `sym_o` never carries 2'b11.
- R9: When the sender switches symbol at the 1 MHz rate (every 25 periods), the first strobe after the switch already reports the new code.
- R10: `valid_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, frequency-locked to the carrier |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw serial pulse-width line |
| sym_o | output | 2 | Last decoded symbol code |
| valid_o | output | 1 | One-cycle strobe for each well-formed period |
| err_o | output | 1 | One-cycle pulse for each malformed period or timeout |

## Verification
The assertions assume the line toggles at most once per sample clock. They also assume the sample clock is frequency-locked to the carrier, so the high time of a period is a whole number of samples. The bench keeps to this by driving one line value per clock, away from the active edge. The bench builds a long sample stream from exact period patterns. These are every transition between the three codes, runs of 25 periods per symbol, a short period, a long period, and stuck-high and stuck-low stretches. From that stream it computes the expected strobe, error and held symbol for every cycle by arithmetic on the positions of the rising edges.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

   typedef enum logic {
      TRK_HUNT = 1'b0,
      TRK_LOCK = 1'b1
   } trk_state_e;

   typedef struct packed {
      logic good;
      logic bad;
   } period_evt_t;

   function automatic int sym_width_needed(input int samples);
      return (samples - 1 <= 2) ? 1 : $clog2(samples - 1);
   endfunction

endpackage

// File: rtl/pwmd_sync.sv
module pwmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pwmd_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) chain[0] <= 1'b0;
               else       chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) chain[i] <= 1'b0;
               else       chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwmd_edge.sv
module pwmd_edge (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pwmd_period.sv
module pwmd_period
   import pwmd_pkg::*;
#(
   parameter int SAMPLES = 4,
   localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             lvl_i,
   input  logic             rise_i,
   output period_evt_t      evt_o,
   output logic [CNT_W-1:0] hi_o
);
   localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(SAMPLES);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   trk_state_e       state_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] hi_q;
   logic             len_full;
   logic             locked;

   assign len_full = (len_q == LEN_FULL);
   assign locked   = (state_q == TRK_LOCK);

   always_comb begin
      evt_o.good = locked & rise_i & len_full;
      evt_o.bad  = locked & ((rise_i & ~len_full) | (~rise_i & len_full));
   end

   assign hi_o = hi_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= TRK_HUNT;
         len_q   <= '0;
         hi_q    <= '0;
      end else if (rise_i) begin
         state_q <= TRK_LOCK;
         len_q   <= ONE;
         hi_q    <= ONE;
      end else begin
         if (locked && len_full) state_q <= TRK_HUNT;
         if (!len_full) len_q <= len_q + ONE;
         if (lvl_i && hi_q != LEN_FULL) hi_q <= hi_q + ONE;
      end
   end
endmodule

// File: rtl/pwmd_decode.sv
module pwmd_decode
   import pwmd_pkg::*;
#(
   parameter int SAMPLES = 4,
   parameter int SYM_W   = 2,
   localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  period_evt_t      evt_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic [SYM_W-1:0] sym_o,
   output logic             valid_o,
   output logic             err_o
);
   logic [CNT_W-1:0] hi_m1;
   logic [SYM_W-1:0] code;

   assign hi_m1 = hi_i - CNT_W'(1);

   generate
      if (SYM_W < sym_width_needed(SAMPLES)) begin : g_narrow
         $error("pwmd_decode: SYM_W too small for SAMPLES");
      end
      if (SYM_W >= CNT_W) begin : g_wide
         assign code = SYM_W'(hi_m1);
      end else begin : g_trunc
         assign code = hi_m1[SYM_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sym_o   <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= evt_i.good;
         err_o   <= evt_i.bad;
         if (evt_i.good) sym_o <= code;
      end
   end
endmodule

// File: rtl/pwm_level_demod.sv
module pwm_level_demod
   import pwmd_pkg::*;
#(
   parameter int PERIOD_SAMPLES = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int SYM_W          = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             line_i,
   output logic [SYM_W-1:0] sym_o,
   output logic             valid_o,
   output logic             err_o
);
   localparam int CNT_W = $clog2(PERIOD_SAMPLES + 1);

   generate
      if (PERIOD_SAMPLES < 3) begin : g_bad_period
         $error("pwm_level_demod: PERIOD_SAMPLES must be at least 3");
      end
   endgenerate

   logic             lvl;
   logic             rise;
   period_evt_t      evt;
   logic [CNT_W-1:0] hi_cnt;

   pwmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (line_i),
      .q_o   (lvl)
   );

   pwmd_edge u_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (lvl),
      .rise_o (rise)
   );

   pwmd_period #(.SAMPLES(PERIOD_SAMPLES)) u_period (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (lvl),
      .rise_i (rise),
      .evt_o  (evt),
      .hi_o   (hi_cnt)
   );

   pwmd_decode #(.SAMPLES(PERIOD_SAMPLES), .SYM_W(SYM_W)) u_decode (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .evt_i   (evt),
      .hi_i    (hi_cnt),
      .sym_o   (sym_o),
      .valid_o (valid_o),
      .err_o   (err_o)
   );
endmodule

// File: rtl/pwm_level_demod_chk.sv
module pwm_level_demod_chk #(
   parameter int PERIOD_SAMPLES = 4,
   parameter int SYM_W          = 2
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [SYM_W-1:0] sym_o,
   input logic             valid_o,
   input logic             err_o
);
   localparam int GAP_W = $clog2(PERIOD_SAMPLES + 1);
   localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(PERIOD_SAMPLES);

   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)            gap_q <= GAP_MAX;
      else if (valid_o)     gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_W'(1);
   end

   a_r2_valid_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> (gap_q >= GAP_W'(PERIOD_SAMPLES - 1)));

   a_r2_valid_single: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o);

   a_r5_err_single: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> !err_o);

   a_r6_sym_moves_on_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(sym_o) |-> valid_o);

   a_r8_no_code3: assert property (@(posedge clk_i) disable iff (rst_i)
      sym_o != SYM_W'(3));

   a_r10_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valid_o && err_o));
endmodule

bind pwm_level_demod pwm_level_demod_chk #(
   .PERIOD_SAMPLES(PERIOD_SAMPLES),
   .SYM_W(SYM_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .sym_o   (sym_o),
   .valid_o (valid_o),
   .err_o   (err_o)
);

// File: tb/pwm_level_demod_tb.sv
module pwm_level_demod_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int MAXT       = 2048;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line = 1'b0;
   logic [1:0] sym;
   logic       valid;
   logic       err;

   bit         stim  [MAXT];
   string      tag   [MAXT];
   bit         ev_v  [MAXT];
   bit         ev_e  [MAXT];
   logic [1:0] ev_s  [MAXT];
   logic [1:0] held  [MAXT];
   int         T = 0;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_level_demod u_dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .line_i  (line),
      .sym_o   (sym),
      .valid_o (valid),
      .err_o   (err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic put(input bit b, input string tg);
      stim[T] = b;
      tag[T]  = tg;
      T++;
   endtask

   task automatic period(input int h, input int len, input string tg);
      for (int i = 0; i < len; i++) put(i < h, tg);
   endtask

   // Expected strobe / error / held code per cycle, from rising-edge positions.
   task automatic build_expect();
      bit armed = 1'b0;
      int last  = 0;
      logic [1:0] h = 2'b00;
      for (int j = 0; j < MAXT; j++) begin
         ev_v[j] = 1'b0;
         ev_e[j] = 1'b0;
         ev_s[j] = 2'b00;
      end
      for (int k = 0; k < T; k++) begin
         bit pr = (k == 0) ? 1'b0 : stim[k-1];
         bit rs = stim[k] && !pr;
         if (rs) begin
            if (armed) begin
               if (k - last == N) begin
                  int highs = 0;
                  for (int m = last; m < k; m++) highs += int'(stim[m]);
                  if (k + 2 < MAXT) begin
                     ev_v[k+2] = 1'b1;
                     ev_s[k+2] = 2'(highs - 1);
                  end
               end else if (k + 2 < MAXT) begin
                  ev_e[k+2] = 1'b1;
               end
            end
            armed = 1'b1;
            last  = k;
         end else if (armed && (k - last == N)) begin
            if (k + 2 < MAXT) ev_e[k+2] = 1'b1;
            armed = 1'b0;
         end
      end
      for (int j = 0; j < MAXT; j++) begin
         if (ev_v[j]) h = ev_s[j];
         held[j] = h;
      end
   endtask

   task automatic verify(input int j);
      string ptag = tag[(j >= 2) ? j - 2 : 0];
      string vreq = (ptag == "R9" || ptag == "R3") ? ptag : "R2";
      string ereq = (ptag == "R4") ? "R4" : "R5";
      string sreq = ev_v[j] ? ((ptag == "R9") ? "R9" : "R1") : "R6";
      chk(valid == ev_v[j], vreq, $sformatf("valid cycle %0d", j), int'(valid), int'(ev_v[j]));
      chk(err == ev_e[j], ereq, $sformatf("err cycle %0d", j), int'(err), int'(ev_e[j]));
      chk(sym == held[j], sreq, $sformatf("sym cycle %0d", j), int'(sym), int'(held[j]));
      chk(sym != 2'b11, "R8", $sformatf("code cycle %0d", j), int'(sym), 0);
      chk(!(valid && err), "R10", $sformatf("overlap cycle %0d", j), int'(valid && err), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R7: reset state
      chk(sym == 2'b00, "R7", "sym in reset", int'(sym), 0);
      chk(valid == 1'b0, "R7", "valid in reset", int'(valid), 0);
      chk(err == 1'b0, "R7", "err in reset", int'(err), 0);

      // R3: idle then a first period that must only align
      for (int i = 0; i < 3; i++) put(1'b0, "R3");
      period(2, N, "R3");
      // R1: every ordered pair of codes
      for (int a = 1; a <= 3; a++)
         for (int b = 1; b <= 3; b++) begin
            for (int r = 0; r < 3; r++) period(a, N, "R1");
            for (int r = 0; r < 3; r++) period(b, N, "R1");
         end
      // R9: 1 MHz symbol rate, 25 periods per symbol
      for (int s = 0; s < 4; s++) begin
         int hv = (s == 3) ? 2 : s + 1;
         for (int r = 0; r < 25; r++) period(hv, N, "R9");
      end
      // R4: short period, then normal decoding
      period(1, N - 1, "R4");
      for (int r = 0; r < 3; r++) period(3, N, "R4");
      // R5: long period, stuck high, stuck low
      period(2, N + 1, "R5");
      for (int r = 0; r < 3; r++) period(1, N, "R5");
      for (int i = 0; i < 9; i++) put(1'b1, "R5");
      put(1'b0, "R5");
      for (int r = 0; r < 3; r++) period(2, N, "R5");
      for (int i = 0; i < 12; i++) put(1'b0, "R5");
      for (int r = 0; r < 3; r++) period(3, N, "R5");
      put(1'b1, "R5");
      for (int i = 0; i < 8; i++) put(1'b0, "R5");

      build_expect();

      rst  = 1'b0;
      line = stim[0];
      // R7: outputs stay idle right after release
      for (int t = 1; t <= T; t++) begin
         @(negedge clk);
         verify(t - 1);
         line = (t < T) ? stim[t] : 1'b0;
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule